// File: doc/BRIEF.md
# External Memory Bus Master Sequencer

This block converts single requests from an on-chip requester into transactions on a synchronous external memory bus. Each transaction opens with a one-clock start strobe. Address, direction and chip select are held from that strobe until the transfer terminates. The transfer ends on a transfer acknowledge. The external bus is modelled as separate data-out, data-out-enable and data-in vectors, which the pad ring joins into one 32-bit bidirectional bus.

Up to `NREG` chip-select regions are matched on a tag field of the address. Each region sets four things: whether the acknowledge is produced internally after a wait-state count or comes from the slave, whether the four enable lines act as write enables or as byte enables, and whether the port is 16 bits wide. Addresses outside every region run as plain bus cycles with no select or strobes, and those cycles always wait for the slave's acknowledge. Two global controls select a 16-bit bus and which half of the bus a narrow port uses. A third global control puts the address on the data lines during the start clock.

A request is taken when `req_ready` is high. Read data is returned right-aligned once per acknowledged beat. A one-clock completion pulse follows the final acknowledge.

Top module: `xbus_master`

## Requirements
- R1: `bus_start` is high for exactly one clock, the clock after the request is accepted, and stays low for the rest of the transaction.
- R2: `bus_addr`, `bus_rnw` (1 = read) and the one-hot `bus_cs` become valid with `bus_start` and hold unchanged through the acknowledging clock of the last beat. When idle, `bus_rnw` is 1 and `bus_cs` is 0.
- R3: For a chip-select read, `bus_oe` rises one clock after `bus_start` and stays high through the final acknowledge. It is never high during a write.
- R4: An access that matches no region asserts no chip select, no `bus_oe` and no enable lines, and it waits for `bus_ta_i`.
- R5: In a region whose external-acknowledge bit is 0, the beat is acknowledged internally W+1 clocks after it starts, where W is the region's 4-bit wait count. The first beat starts at the start strobe. The acknowledge is driven on `bus_ta_o` with `bus_ta_oe` high, and `bus_ta_i` is ignored.
- R6: In a region whose external-acknowledge bit is 1, each beat ends only in the clock where `bus_ta_i` is high, and `bus_ta_oe` stays low.
- R7: A burst read carries four beats. Each acknowledged beat gives one `rsp_rvalid` with data, and for internal acknowledge the wait count is reloaded for every beat. A write takes one acknowledge and gives no `rsp_rvalid`, even if `req_burst` is set.
- R8: With the region's byte-enable bit at 0, `bus_we_be` is driven only on writes. With the bit at 1, it is driven on both reads and writes. In either case it is driven from the clock after the strobe through termination.
- R9: Lane k is `data[8k+7:8k]`, and `bus_we_be[k]` enables it. On a 32-bit port a byte (size 0) uses lane `addr[1:0]`, a half (size 1) uses lanes 1:0 or 3:2 as `addr[1]` is 0 or 1, and a word (size 2) uses all four lanes. Write data is given right-aligned and is copied onto every lane. Read data is returned right-aligned.
- R10: On a 16-bit port (`cfg_bus16` or the region's port bit), only lanes 1:0 (`cfg_half_upper` = 0) or lanes 3:2 (= 1) are used. A byte picks the lane within that half by `addr[0]`, and a half or word uses both lanes.
- R11: With `cfg_mux_addr` set, the start clock drives `bus_addr` on `bus_data_o` with `bus_data_oe` high. Write data is driven from the next clock onward, and without the mux the data lines are not driven in the start clock.
- R12: In the clock after the final acknowledge, `req_ready` is high and `rsp_done` pulses for one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this clock |
| req_write | input | 1 | 1 = write |
| req_burst | input | 1 | Four-beat read burst |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | 0 byte, 1 half, 2 word |
| req_wdata | input | 32 | Right-aligned write data |
| rsp_rvalid | output | 1 | Read beat data valid |
| rsp_rdata | output | 32 | Right-aligned read data |
| rsp_done | output | 1 | Completion pulse |
| cfg_bus16 | input | 1 | Whole bus is 16 bits wide |
| cfg_half_upper | input | 1 | Narrow port uses lanes 3:2 |
| cfg_mux_addr | input | 1 | Address on data in start clock |
| cfg_rgn_en | input | NREG | Region enable |
| cfg_rgn_tag | input | NREG*TAG_W | Region address tags |
| cfg_rgn_ext_ack | input | NREG | Slave supplies acknowledge |
| cfg_rgn_byte_en | input | NREG | Enables act as byte enables |
| cfg_rgn_port16 | input | NREG | Region is a 16-bit port |
| cfg_rgn_wait | input | NREG*WAIT_W | Wait-state counts |
| bus_start | output | 1 | Transfer start strobe |
| bus_rnw | output | 1 | 1 = read |
| bus_oe | output | 1 | Output enable |
| bus_we_be | output | 4 | Write/byte enables per lane |
| bus_addr | output | AW | Address |
| bus_cs | output | NREG | One-hot chip selects |
| bus_data_o | output | 32 | Data driven to bus |
| bus_data_oe | output | 1 | Data driver enable |
| bus_data_i | input | 32 | Data from bus |
| bus_ta_i | input | 1 | Acknowledge from slave |
| bus_ta_o | output | 1 | Internally generated acknowledge |
| bus_ta_oe | output | 1 | Acknowledge driver enable |

## Verification
Reads and writes are run at each size and lane offset on a 32-bit port. Comparing the lane masks and the extracted data shows whether lane selection and right-alignment are correct. Internal-acknowledge regions with wait counts of 0, 2 and 5 are set against a slave-acknowledged region that holds its acknowledge back for three clocks, and against an unmatched address. These cases show that the acknowledge source follows the region and that stray `bus_ta_i` pulses are ignored. Burst reads with non-zero and zero wait counts check the per-beat reload, and a write with the burst flag set checks that a write gets a single acknowledge. The 16-bit cases flip the half-select and come in through both the region bit and the global bit. The address-multiplexed write shows what the data lines carry in the start clock.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xsize_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BEAT  = 2'd2
  } xstate_e;

  // Lanes touched by an access; lane k is data[8k+7:8k].
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] size,
                                                 input logic [1:0] a,
                                                 input logic narrow,
                                                 input logic upper);
    logic [LANES-1:0] m;
    if (narrow) begin
      if (size == SZ_BYTE) m = upper ? (a[0] ? 4'b1000 : 4'b0100)
                                     : (a[0] ? 4'b0010 : 4'b0001);
      else                 m = upper ? 4'b1100 : 4'b0011;
    end else begin
      case (size)
        SZ_BYTE: m = 4'b0001 << a;
        SZ_HALF: m = a[1] ? 4'b1100 : 4'b0011;
        default: m = 4'b1111;
      endcase
    end
    return m;
  endfunction

  // Copy right-aligned write data onto every lane.
  function automatic logic [31:0] wr_image(input logic [1:0] size, input logic [31:0] w);
    case (size)
      SZ_BYTE: return {4{w[7:0]}};
      SZ_HALF: return {2{w[15:0]}};
      default: return w;
    endcase
  endfunction

  // Shift the lowest enabled lane to bit 0 and clear unused bytes.
  function automatic logic [31:0] rd_extract(input logic [LANES-1:0] m, input logic [31:0] d);
    logic [31:0] s;
    int lo;
    lo = 0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (m[k]) lo = k;
    end
    s = d >> (8 * lo);
    case ($countones(m))
      1:       s = s & 32'h0000_00FF;
      2:       s = s & 32'h0000_FFFF;
      default: s = s;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/xbus_region_dec.sv
module xbus_region_dec #(
  parameter int NREG    = 4,
  parameter int TAG_W   = 4,
  parameter int TAG_LSB = 28,
  parameter int AW      = 32,
  parameter int WAIT_W  = 4
) (
  input  logic [AW-1:0]          addr,
  input  logic [NREG-1:0]        cfg_en,
  input  logic [NREG*TAG_W-1:0]  cfg_tag,
  input  logic [NREG-1:0]        cfg_ext_ack,
  input  logic [NREG-1:0]        cfg_byte_en,
  input  logic [NREG-1:0]        cfg_port16,
  input  logic [NREG*WAIT_W-1:0] cfg_wait,
  output logic                   hit,
  output logic [NREG-1:0]        sel,
  output logic                   ext_ack,
  output logic                   byte_en,
  output logic                   port16,
  output logic [WAIT_W-1:0]      wait_val
);

  logic [NREG-1:0] match;

  for (genvar g = 0; g < NREG; g++) begin : g_match
    assign match[g] = cfg_en[g] &&
                      (addr[TAG_LSB +: TAG_W] == cfg_tag[g*TAG_W +: TAG_W]);
  end

  // Lowest-numbered matching region wins.
  always_comb begin
    hit      = 1'b0;
    sel      = '0;
    ext_ack  = 1'b0;
    byte_en  = 1'b0;
    port16   = 1'b0;
    wait_val = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit      = 1'b1;
        sel      = '0;
        sel[i]   = 1'b1;
        ext_ack  = cfg_ext_ack[i];
        byte_en  = cfg_byte_en[i];
        port16   = cfg_port16[i];
        wait_val = cfg_wait[i*WAIT_W +: WAIT_W];
      end
    end
  end

endmodule

// File: rtl/xbus_wait_timer.sv
module xbus_wait_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expire
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expire = run && (cnt == '0);

endmodule

// File: rtl/xbus_lane_steer.sv
module xbus_lane_steer (
  input  logic [1:0]  size,
  input  logic [1:0]  addr_lo,
  input  logic        narrow,
  input  logic        upper,
  input  logic [31:0] wdata,
  input  logic [3:0]  held_mask,
  input  logic [31:0] bus_in,
  output logic [3:0]  mask,
  output logic [31:0] wimg,
  output logic [31:0] rdata
);

  import xbus_pkg::*;

  assign mask  = lane_mask(size, addr_lo, narrow, upper);
  assign wimg  = wr_image(size, wdata);
  assign rdata = rd_extract(held_mask, bus_in);

endmodule

// File: rtl/xbus_master.sv
module xbus_master #(
  parameter int NREG      = 4,
  parameter int TAG_W     = 4,
  parameter int TAG_LSB   = 28,
  parameter int AW        = 32,
  parameter int WAIT_W    = 4,
  parameter int BURST_LEN = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic                   req_burst,
  input  logic [AW-1:0]          req_addr,
  input  logic [1:0]             req_size,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_rvalid,
  output logic [31:0]            rsp_rdata,
  output logic                   rsp_done,
  input  logic                   cfg_bus16,
  input  logic                   cfg_half_upper,
  input  logic                   cfg_mux_addr,
  input  logic [NREG-1:0]        cfg_rgn_en,
  input  logic [NREG*TAG_W-1:0]  cfg_rgn_tag,
  input  logic [NREG-1:0]        cfg_rgn_ext_ack,
  input  logic [NREG-1:0]        cfg_rgn_byte_en,
  input  logic [NREG-1:0]        cfg_rgn_port16,
  input  logic [NREG*WAIT_W-1:0] cfg_rgn_wait,
  output logic                   bus_start,
  output logic                   bus_rnw,
  output logic                   bus_oe,
  output logic [3:0]             bus_we_be,
  output logic [AW-1:0]          bus_addr,
  output logic [NREG-1:0]        bus_cs,
  output logic [31:0]            bus_data_o,
  output logic                   bus_data_oe,
  input  logic [31:0]            bus_data_i,
  input  logic                   bus_ta_i,
  output logic                   bus_ta_o,
  output logic                   bus_ta_oe
);

  import xbus_pkg::*;

  localparam int BC_W = $clog2(BURST_LEN + 1);

  xstate_e state;

  // Held transaction attributes.
  logic              r_write;
  logic [AW-1:0]     r_addr;
  logic [3:0]        r_mask;
  logic [31:0]       r_wimg;
  logic              r_hit;
  logic [NREG-1:0]   r_sel;
  logic              r_ext;
  logic              r_be;
  logic [WAIT_W-1:0] r_wait;
  logic              r_mux;
  logic [BC_W-1:0]   beats_left;
  logic              done_q;

  // Decode of the incoming request.
  logic              d_hit, d_ext, d_be, d_port16;
  logic [NREG-1:0]   d_sel;
  logic [WAIT_W-1:0] d_wait;
  logic [3:0]        d_mask;
  logic [31:0]       d_wimg;
  logic [31:0]       rd_aligned;

  // Named internal events.
  logic accept;
  logic int_ack_mode;
  logic t_expire;
  logic beat_ack;
  logic last_beat;
  logic term;
  logic in_beat;

  xbus_region_dec #(
    .NREG(NREG), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB), .AW(AW), .WAIT_W(WAIT_W)
  ) u_dec (
    .addr        (req_addr),
    .cfg_en      (cfg_rgn_en),
    .cfg_tag     (cfg_rgn_tag),
    .cfg_ext_ack (cfg_rgn_ext_ack),
    .cfg_byte_en (cfg_rgn_byte_en),
    .cfg_port16  (cfg_rgn_port16),
    .cfg_wait    (cfg_rgn_wait),
    .hit         (d_hit),
    .sel         (d_sel),
    .ext_ack     (d_ext),
    .byte_en     (d_be),
    .port16      (d_port16),
    .wait_val    (d_wait)
  );

  xbus_lane_steer u_lanes (
    .size      (req_size),
    .addr_lo   (req_addr[1:0]),
    .narrow    (cfg_bus16 | d_port16),
    .upper     (cfg_half_upper),
    .wdata     (req_wdata),
    .held_mask (r_mask),
    .bus_in    (bus_data_i),
    .mask      (d_mask),
    .wimg      (d_wimg),
    .rdata     (rd_aligned)
  );

  assign accept       = (state == ST_IDLE) && req_valid;
  assign in_beat      = (state == ST_BEAT);
  assign int_ack_mode = r_hit && !r_ext;
  assign last_beat    = (beats_left == BC_W'(1));
  assign beat_ack     = in_beat && (int_ack_mode ? t_expire : bus_ta_i);
  assign term         = beat_ack && last_beat;

  xbus_wait_timer #(.W(WAIT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     ((state == ST_START) || beat_ack),
    .load_val (r_wait),
    .run      (in_beat && int_ack_mode),
    .expire   (t_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      r_write    <= 1'b0;
      r_addr     <= '0;
      r_mask     <= '0;
      r_wimg     <= '0;
      r_hit      <= 1'b0;
      r_sel      <= '0;
      r_ext      <= 1'b0;
      r_be       <= 1'b0;
      r_wait     <= '0;
      r_mux      <= 1'b0;
      beats_left <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= term;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state      <= ST_START;
            r_write    <= req_write;
            r_addr     <= req_addr;
            r_mask     <= d_mask;
            r_wimg     <= d_wimg;
            r_hit      <= d_hit;
            r_sel      <= d_sel;
            r_ext      <= d_ext;
            r_be       <= d_be;
            r_wait     <= d_wait;
            r_mux      <= cfg_mux_addr;
            beats_left <= (req_burst && !req_write) ? BC_W'(BURST_LEN) : BC_W'(1);
          end
        end
        ST_START: state <= ST_BEAT;
        ST_BEAT: begin
          if (beat_ack) begin
            if (last_beat) state <= ST_IDLE;
            else           beats_left <= beats_left - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Bus side.
  assign bus_start   = (state == ST_START);
  assign bus_rnw     = (state == ST_IDLE) ? 1'b1 : !r_write;
  assign bus_addr    = (state == ST_IDLE) ? '0 : r_addr;
  assign bus_cs      = (state == ST_IDLE) ? '0 : r_sel;
  assign bus_oe      = in_beat && r_hit && !r_write;
  assign bus_we_be   = (in_beat && r_hit && (r_write || r_be)) ? r_mask : 4'b0000;
  assign bus_data_oe = (bus_start && r_mux) || (in_beat && r_write);
  assign bus_data_o  = bus_start ? (r_mux ? r_addr : 32'h0) : (r_write ? r_wimg : 32'h0);
  assign bus_ta_oe   = in_beat && int_ack_mode;
  assign bus_ta_o    = t_expire;

  // Request side.
  assign req_ready   = (state == ST_IDLE);
  assign rsp_rvalid  = beat_ack && !r_write;
  assign rsp_rdata   = rd_aligned;
  assign rsp_done    = done_q;

endmodule

// File: rtl/xbus_master_chk.sv
module xbus_master_chk #(
  parameter int NREG = 4,
  parameter int AW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            bus_start,
  input logic            bus_rnw,
  input logic            bus_oe,
  input logic [3:0]      bus_we_be,
  input logic [AW-1:0]   bus_addr,
  input logic [NREG-1:0] bus_cs,
  input logic [31:0]     bus_data_o,
  input logic            bus_data_oe,
  input logic            bus_ta_o,
  input logic            bus_ta_oe,
  input logic            rsp_rvalid,
  input logic            rsp_done,
  input logic            beat_ack
);

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !bus_start); // R1

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !bus_start) |-> ($stable(bus_addr) && $stable(bus_rnw) && $stable(bus_cs))); // R2

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_cs)); // R2

  AST_OE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && bus_rnw && (bus_cs != '0)) |=> bus_oe); // R3

  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_rnw && !bus_start)); // R3

  AST_NO_CS_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs == '0) |-> (!bus_oe && bus_we_be == 4'b0000)); // R4

  AST_TA_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ta_o |-> bus_ta_oe); // R5

  AST_WRITE_NO_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rnw |-> !rsp_rvalid); // R7

  AST_MUX_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && bus_data_oe) |-> (bus_data_o == bus_addr)); // R11

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (req_ready && $past(beat_ack))); // R12

endmodule

bind xbus_master xbus_master_chk #(.NREG(NREG), .AW(AW)) u_chk (.*);

// File: tb/xbus_master_test.sv
`timescale 1ns/1ps
module xbus_master_test;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write, req_burst;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_rvalid, rsp_done;
  logic [31:0] rsp_rdata;
  logic        cfg_bus16, cfg_half_upper, cfg_mux_addr;
  logic [3:0]  cfg_rgn_en, cfg_rgn_ext_ack, cfg_rgn_byte_en, cfg_rgn_port16;
  logic [15:0] cfg_rgn_tag, cfg_rgn_wait;
  logic        bus_start, bus_rnw, bus_oe, bus_data_oe, bus_ta_i, bus_ta_o, bus_ta_oe;
  logic [3:0]  bus_we_be, bus_cs;
  logic [31:0] bus_addr, bus_data_o, bus_data_i;

  xbus_master uut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    bit          is_done;
    logic [31:0] d;
    string       r;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   n_checks = 0;
  int   n_fail   = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] lane_bits(input logic [3:0] l);
    logic [31:0] b;
    for (int k = 0; k < 4; k++) b[8*k +: 8] = {8{l[k]}};
    return b;
  endfunction

  // Monitor: pops scoreboard items as results appear.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_rvalid) begin
        n_checks++;
        if (q.size() == 0 || q[0].is_done) begin
          n_fail++;
          $display("FAIL R7 unexpected read beat actual=%h expected=none", rsp_rdata);
        end else begin
          e = q.pop_front();
          if (rsp_rdata !== e.d) begin
            n_fail++;
            $display("FAIL %s read data actual=%h expected=%h", e.r, rsp_rdata, e.d);
          end
        end
      end
      if (rsp_done) begin
        n_checks++;
        if (q.size() == 0 || !q[0].is_done) begin
          n_fail++;
          $display("FAIL R12 unexpected done actual=1 expected=0");
        end else begin
          e = q.pop_front();
        end
      end
    end
  end

  // Driver and slave model for one transaction.
  task automatic run(input string tag, input logic wr, input logic burst,
                     input logic [31:0] addr, input logic [1:0] size,
                     input logic [31:0] wdata, input logic [31:0] rbus,
                     input logic [31:0] exp_rd, input int ext, input int wt,
                     input logic [3:0] exp_cs, input logic [3:0] lanes,
                     input logic en_rd, input logic [31:0] exp_wbus, input logic mux);
    int  nb;
    int  c;
    bit  acked;
    logic [31:0] lm;
    lm = lane_bits(lanes);
    nb = (burst && !wr) ? 4 : 1;
    tick;
    req_valid = 1'b1; req_write = wr; req_burst = burst;
    req_addr = addr; req_size = size; req_wdata = wdata;
    #1;
    chk("R12", req_ready, 1'b1);
    tick;
    req_valid = 1'b0;
    #1;
    chk("R1", bus_start, 1'b1);
    chk("R2", bus_addr, addr);
    chk("R2", bus_rnw, !wr);
    chk("R2", bus_cs, exp_cs);
    chk("R3", bus_oe, 1'b0);
    chk("R11", bus_data_oe, mux);
    if (mux) chk("R11", bus_data_o, addr);
    for (int beat = 0; beat < nb; beat++) begin
      c = 0;
      acked = 0;
      while (!acked && c < 40) begin
        tick;
        bus_data_i = rbus + beat;
        bus_ta_i   = (ext < 0) ? (c != wt) : (c == ext);
        acked      = (ext < 0) ? (c == wt) : (c == ext);
        if (acked && !wr) q.push_back('{0, exp_rd + beat, tag});
        #1;
        chk("R1", bus_start, 1'b0);
        chk("R2", bus_addr, addr);
        chk("R2", bus_cs, exp_cs);
        chk("R3", bus_oe, (exp_cs != 0) && !wr);
        chk((exp_cs == 0) ? "R4" : "R8", bus_we_be,
            ((exp_cs != 0) && (wr || en_rd)) ? lanes : 4'b0000);
        if (ext < 0) begin
          chk("R5", bus_ta_o, c == wt);
          chk("R5", bus_ta_oe, 1'b1);
        end else begin
          chk("R6", bus_ta_oe, 1'b0);
        end
        if (wr) begin
          chk("R11", bus_data_oe, 1'b1);
          chk("R9", bus_data_o & lm, exp_wbus & lm);
        end
        c++;
      end
    end
    tick;
    bus_ta_i = 1'b0;
    q.push_back('{1, 32'h0, "R12"});
    #1;
    chk("R12", req_ready, 1'b1);
    chk("R2", bus_cs, 4'b0000);
    chk("R3", bus_oe, 1'b0);
    tick;
    #1;
    chk("R12", rsp_done, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_burst = 1'b0;
    req_addr = '0; req_size = '0; req_wdata = '0;
    cfg_bus16 = 1'b0; cfg_half_upper = 1'b0; cfg_mux_addr = 1'b0;
    cfg_rgn_en      = 4'b1111;
    cfg_rgn_tag     = {4'h4, 4'h3, 4'h2, 4'h1};
    cfg_rgn_ext_ack = 4'b0010;
    cfg_rgn_byte_en = 4'b0110;
    cfg_rgn_port16  = 4'b0100;
    cfg_rgn_wait    = {4'd5, 4'd0, 4'd0, 4'd2};
    bus_data_i = '0; bus_ta_i = 1'b0;
    repeat (3) tick;
    chk("R1", bus_start, 1'b0);
    chk("R12", req_ready, 1'b1);
    chk("R2", bus_rnw, 1'b1);
    chk("R2", bus_cs, 4'b0000);
    chk("R3", bus_oe, 1'b0);
    chk("R4", bus_we_be, 4'b0000);
    chk("R12", rsp_done, 1'b0);
    rst_n = 1'b1;
    tick;

    run("R3", 0, 0, 32'h1000_0010, 2, 0, 32'h8765_4321, 32'h8765_4321, -1, 2, 4'b0001, 4'b1111, 0, 0, 0);
    run("R8", 1, 0, 32'h1000_0020, 2, 32'hA5A5_0F0F, 0, 0, -1, 2, 4'b0001, 4'b1111, 0, 32'hA5A5_0F0F, 0);
    run("R9", 1, 0, 32'h1000_0003, 0, 32'h0000_0077, 0, 0, -1, 2, 4'b0001, 4'b1000, 0, 32'h7700_0000, 0);
    run("R9", 0, 0, 32'h1000_0002, 1, 0, 32'h1234_5678, 32'h0000_1234, -1, 2, 4'b0001, 4'b1100, 0, 0, 0);
    run("R6", 0, 0, 32'h2000_0001, 0, 0, 32'h1122_3344, 32'h0000_0033, 3, 0, 4'b0010, 4'b0010, 1, 0, 0);
    run("R7", 0, 1, 32'h1000_0100, 2, 0, 32'h0000_0100, 32'h0000_0100, -1, 2, 4'b0001, 4'b1111, 0, 0, 0);
    run("R7", 1, 1, 32'h4000_0000, 2, 32'h0BAD_CAFE, 0, 0, -1, 5, 4'b1000, 4'b1111, 0, 32'h0BAD_CAFE, 0);
    run("R4", 0, 0, 32'hF000_0000, 2, 0, 32'hCAFE_F00D, 32'hCAFE_F00D, 1, 0, 4'b0000, 4'b0000, 0, 0, 0);
    cfg_half_upper = 1'b1;
    run("R10", 0, 0, 32'h3000_0000, 1, 0, 32'hAABB_CCDD, 32'h0000_AABB, -1, 0, 4'b0100, 4'b1100, 1, 0, 0);
    cfg_half_upper = 1'b0;
    run("R10", 1, 0, 32'h3000_0001, 0, 32'h0000_005A, 0, 0, -1, 0, 4'b0100, 4'b0010, 1, 32'h0000_5A00, 0);
    cfg_mux_addr = 1'b1;
    run("R11", 1, 0, 32'h1000_0040, 2, 32'hDEAD_BEEF, 0, 0, -1, 2, 4'b0001, 4'b1111, 0, 32'hDEAD_BEEF, 1);
    cfg_mux_addr = 1'b0;
    cfg_bus16 = 1'b1;
    run("R10", 0, 0, 32'h1000_0000, 0, 0, 32'h0000_00AB, 32'h0000_00AB, -1, 2, 4'b0001, 4'b0001, 0, 0, 0);
    cfg_half_upper = 1'b1;
    run("R10", 0, 0, 32'h1000_0001, 0, 0, 32'h9A00_0000, 32'h0000_009A, -1, 2, 4'b0001, 4'b1000, 0, 0, 0);
    cfg_bus16 = 1'b0; cfg_half_upper = 1'b0;
    run("R5", 0, 1, 32'h3000_0000, 1, 0, 32'h0000_4000, 32'h0000_4000, -1, 0, 4'b0100, 4'b0011, 1, 0, 0);

    repeat (3) tick;
    chk("R7", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule